// File: doc/BRIEF.md
# Serial Flash Command and Protection Engine

This block is the slave-side command engine of a small serial flash that sits on an SPI bus in mode 0. It runs on a system clock that is much faster than the serial clock. It oversamples chip select, serial clock, data in, write-protect and hold through synchronisers, and it assembles opcode, address and data bytes. It keeps a status register that holds a busy flag, a write-enable latch, a two-bit block-protect code and a status-freeze bit. It answers status, identification, signature and array-read commands on the serial data out pin.

Commands that change the array or the status register are decided when chip select rises. Such a command is accepted only if the write-enable latch is set, the clock count is a whole number of bytes, the part is awake and idle, and the target lies outside the protected sectors. An accepted command leaves as a one-cycle start pulse on a backend port, which carries the operation, the address, the length and the new status value. Page data waits in a one-page buffer that the backend reads by index. The backend ends the operation with a done pulse. Array reads use a separate address/data port that the backend answers within one system clock.

Top module: `sfc_flash_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, the data-out enable is low and no backend start has been issued.
- R2: Opcode 05h returns the status byte on every following byte, with busy in bit 0, write-enable latch in bit 1, block-protect code in bits 3:2 and the freeze bit in bit 7, MSB first.
- R3: Opcode 06h sets the write-enable latch and 04h clears it, taking effect at deselect when the part is idle and awake.
- R4: Program (02h), sector erase (D8h), bulk erase (C7h) and status write (01h) issue no backend start unless the write-enable latch is set.
- R5: A modifying command whose clock count at deselect is not a multiple of eight is discarded, and the write-enable latch stays set.
- R6: Program or sector erase aimed at a protected sector is rejected; sector = address bits 17:16, code 01 locks sector 3, 10 locks sectors 2–3, 11 locks all. An accepted request carries backend op 0 (program) or 1 (sector erase) and the 18-bit start address.
- R7: Bulk erase (backend op 2) is accepted only when the block-protect code is 00.
- R8: Status write (backend op 3) is rejected when write-protect is low and the freeze bit is set; otherwise it loads bits 7 and 3:2 from the data byte and reports them on be_stat.
- R9: Busy is set from the backend start until be_done; be_done also clears the write-enable latch, and while busy all commands other than status read are ignored.
- R10: Opcode B9h enters deep power-down, where status, identification and read give no output and modifying commands are ignored; ABh leaves it and returns 11h on each following byte.
- R11: Opcode 9Fh returns 20h and then 12h.
- R12: Opcode 03h with a 3-byte address returns rd_data for consecutive addresses from the fourth byte on, with rd_addr advancing by one per byte.
- R13: Program data bytes are stored at page offsets that wrap modulo 256 from the start offset; be_len reports the byte count, saturating at 256.
- R14: While hold is low the serial clock is ignored and data-out is disabled, and the bit count is kept, so a byte split around a hold is received whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in |
| spi_wp_n | input | 1 | Write-protect, active low |
| spi_hold_n | input | 1 | Hold, active low |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| rd_addr | output | 18 | Array read address |
| rd_data | input | 8 | Array read data, valid one clock after rd_addr |
| be_start | output | 1 | One-cycle start of a backend operation |
| be_op | output | 2 | 0 program, 1 sector erase, 2 bulk erase, 3 status write |
| be_addr | output | 18 | Start address of the operation |
| be_len | output | 9 | Program byte count, 1 to 256 |
| be_stat | output | 8 | Status value to store for a status write |
| be_buf_idx | input | 8 | Page buffer read index |
| be_buf_data | output | 8 | Page buffer byte at be_buf_idx |
| be_done | input | 1 | Backend operation finished |

## Verification
The bench goes after the acceptance gates one at a time. It sends a sector erase one bit past a byte boundary, which a design without the modulo-eight check would launch. It issues program, erase and status writes without the latch, against each block-protect code, with write-protect low, during busy and during power-down, and a design missing any gate would produce a backend start that the bench counts. A program that starts at offset FEh and one of 257 bytes show whether the page buffer wraps and the length saturates. A split opcode across a hold shows whether the bit count is wrongly reset or advanced during the pause.

// File: rtl/sfc_pkg.sv
// Shared opcodes, backend operation codes and fixed response bytes for the
// serial flash command engine. Assumes an 8-bit opcode space.
package sfc_pkg;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SERASE = 8'hD8;
    localparam logic [7:0] OP_BERASE = 8'hC7;
    localparam logic [7:0] OP_SLEEP  = 8'hB9;
    localparam logic [7:0] OP_WAKE   = 8'hAB;
    localparam logic [7:0] OP_IDENT  = 8'h9F;

    localparam logic [7:0] SIG_LEGACY = 8'h11;
    localparam logic [7:0] ID_HI      = 8'h20;
    localparam logic [7:0] ID_LO      = 8'h12;

    typedef enum logic [1:0] {
        BE_PROG = 2'd0,
        BE_SECT = 2'd1,
        BE_BULK = 2'd2,
        BE_STAT = 2'd3
    } be_op_e;
endpackage

// File: rtl/sfc_spi_front.sv
// Serial front end: synchronises the SPI pins into the system clock domain,
// detects serial clock edges (mode 0), shifts in bytes and counts bits and
// bytes while selected. Assumes each serial clock phase lasts at least four
// system clocks. Hold low masks clock edges but keeps the counters.
module sfc_spi_front #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             mosi,
    input  logic             hold_n,
    input  logic             wp_n,
    output logic             sel,
    output logic             hold_ok,
    output logic             wp_ok,
    output logic             fall,
    output logic             byte_done,
    output logic [7:0]       rx_byte,
    output logic [2:0]       bit_cnt,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             desel
);
    logic [1:0] cs_ff, sck_ff, mosi_ff, hold_ff, wp_ff;
    logic       sck_d, sel_d;
    logic [6:0] sh;
    logic       rise;

    // Two-stage synchronisers plus previous-value registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_ff   <= 2'b11;
            sck_ff  <= 2'b00;
            mosi_ff <= 2'b00;
            hold_ff <= 2'b11;
            wp_ff   <= 2'b11;
            sck_d   <= 1'b0;
            sel_d   <= 1'b0;
        end else begin
            cs_ff   <= {cs_ff[0], cs_n};
            sck_ff  <= {sck_ff[0], sck};
            mosi_ff <= {mosi_ff[0], mosi};
            hold_ff <= {hold_ff[0], hold_n};
            wp_ff   <= {wp_ff[0], wp_n};
            sck_d   <= sck_ff[1];
            sel_d   <= sel;
        end
    end

    assign sel     = !cs_ff[1];
    assign hold_ok = hold_ff[1];
    assign wp_ok   = wp_ff[1];
    assign desel   = sel_d && !sel;
    assign rise    = sel && hold_ok && sck_ff[1] && !sck_d;
    assign fall    = sel && hold_ok && !sck_ff[1] && sck_d;

    assign byte_done = rise && (bit_cnt == 3'd7);
    assign rx_byte   = {sh, mosi_ff[1]};

    // Shift register and bit/byte counters, cleared whenever deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            sh       <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
        end else if (rise) begin
            sh      <= {sh[5:0], mosi_ff[1]};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7 && byte_cnt != '1)
                byte_cnt <= byte_cnt + CNT_W'(1);
        end
    end

    a_r14_hold_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_ok && sel) |=> $stable(bit_cnt));
    a_r5_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> (bit_cnt == 3'd0 && byte_cnt == '0));
endmodule

// File: rtl/sfc_prot_decode.sv
// Block-protect decoder: from the two-bit protect code and a sector number,
// says whether that sector is locked and whether nothing is locked.
// Assumes the locked region always grows downward from the top sector.
module sfc_prot_decode #(
    parameter int SECT_W = 2
) (
    input  logic [1:0]        bp,
    input  logic [SECT_W-1:0] sect,
    output logic              sect_locked,
    output logic              none_locked
);
    localparam int NSECT = 1 << SECT_W;
    localparam logic [SECT_W:0] FIRST_QTR  = (SECT_W + 1)'(NSECT - NSECT / 4);
    localparam logic [SECT_W:0] FIRST_HALF = (SECT_W + 1)'(NSECT / 2);

    logic [SECT_W:0] first_locked;

    // Lowest locked sector for each protect code.
    always_comb begin
        case (bp)
            2'b01:   first_locked = FIRST_QTR;
            2'b10:   first_locked = FIRST_HALF;
            2'b11:   first_locked = '0;
            default: first_locked = (SECT_W + 1)'(NSECT);
        endcase
    end

    assign sect_locked = {1'b0, sect} >= first_locked;
    assign none_locked = (bp == 2'b00);

    // Full-protect code must lock every sector.
    always_comb begin
        if (bp == 2'b11)
            a_r6_all_locked: assert (sect_locked);
    end
endmodule

// File: rtl/sfc_page_buf.sv
// One-page data buffer: written by the command engine as program bytes
// arrive, read asynchronously by the backend by byte index. No reset on
// the storage; only bytes written by the current command are meaningful.
module sfc_page_buf #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PAGE_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [PAGE_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << PAGE_W;

    logic [7:0] mem [DEPTH];

    // Single write port.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sfc_flash_ctrl.sv
// Serial flash command engine top. Decodes opcodes, returns status,
// identification, signature and array data, gates modifying commands on
// latch, byte alignment, power state, busy and sector protection, and hands
// accepted work to a backend with a start/done handshake.
// Assumes the backend answers rd_addr within one clock and raises be_done
// only while an operation is outstanding.
module sfc_flash_ctrl #(
    parameter int ADDR_W = 18,
    parameter int PAGE_W = 8,
    parameter int SECT_W = 2,
    parameter int CNT_W  = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_cs_n,
    input  logic                spi_sck,
    input  logic                spi_mosi,
    input  logic                spi_wp_n,
    input  logic                spi_hold_n,
    output logic                spi_miso,
    output logic                spi_miso_oe,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic [7:0]          rd_data,
    output logic                be_start,
    output logic [1:0]          be_op,
    output logic [ADDR_W-1:0]   be_addr,
    output logic [PAGE_W:0]     be_len,
    output logic [7:0]          be_stat,
    input  logic [PAGE_W-1:0]   be_buf_idx,
    output logic [7:0]          be_buf_data,
    input  logic                be_done
);
    import sfc_pkg::*;

    localparam int LEN_W = PAGE_W + 1;
    localparam logic [LEN_W-1:0] PAGE_BYTES = LEN_W'(1 << PAGE_W);

    logic             sel, hold_ok, wp_ok, fall, byte_done, desel;
    logic [7:0]       rx_byte;
    logic [2:0]       bit_cnt;
    logic [CNT_W-1:0] byte_cnt;

    logic [7:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        wrsr_bp;
    logic              wrsr_fz;
    logic [PAGE_W-1:0] pp_ptr;
    logic [LEN_W-1:0]  pp_cnt;
    logic              wel_q, busy_q, srwd_q, dpd_q;
    logic [1:0]        bp_q;
    logic [7:0]        tx_sh;
    logic              miso_q, tx_act;
    logic              be_start_q;
    be_op_e            be_op_q;
    logic [ADDR_W-1:0] be_addr_q;
    logic [LEN_W-1:0]  be_len_q;
    logic [7:0]        be_stat_q;

    logic              sect_locked, none_locked;
    logic [7:0]        stat_byte, resp_byte;
    logic              resp_ok, idle_ok, mod_ok, have1, frozen, buf_we;

    sfc_spi_front #(.CNT_W(CNT_W)) u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck),
        .mosi(spi_mosi), .hold_n(spi_hold_n), .wp_n(spi_wp_n),
        .sel(sel), .hold_ok(hold_ok), .wp_ok(wp_ok), .fall(fall),
        .byte_done(byte_done), .rx_byte(rx_byte), .bit_cnt(bit_cnt),
        .byte_cnt(byte_cnt), .desel(desel)
    );

    sfc_prot_decode #(.SECT_W(SECT_W)) u_prot (
        .bp(bp_q), .sect(addr_q[ADDR_W-1 -: SECT_W]),
        .sect_locked(sect_locked), .none_locked(none_locked)
    );

    sfc_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .we(buf_we), .waddr(pp_ptr), .wdata(rx_byte),
        .raddr(be_buf_idx), .rdata(be_buf_data)
    );

    assign stat_byte = {srwd_q, 3'b000, bp_q, wel_q, busy_q};
    assign idle_ok   = !busy_q && !dpd_q;
    assign mod_ok    = idle_ok && wel_q && (bit_cnt == 3'd0);
    assign have1     = byte_cnt >= CNT_W'(1);
    assign frozen    = srwd_q && !wp_ok;
    assign buf_we    = byte_done && (op_q == OP_PROG) && idle_ok
                       && (byte_cnt >= CNT_W'(4));

    // Next outgoing byte and whether this command may drive data out now.
    always_comb begin
        resp_ok   = 1'b0;
        resp_byte = 8'h00;
        case (op_q)
            OP_RDSR: begin
                resp_ok   = !dpd_q;
                resp_byte = stat_byte;
            end
            OP_IDENT: begin
                resp_ok   = idle_ok;
                resp_byte = (byte_cnt == CNT_W'(1)) ? ID_HI :
                            (byte_cnt == CNT_W'(2)) ? ID_LO : 8'h00;
            end
            OP_WAKE: begin
                resp_ok   = !busy_q;
                resp_byte = SIG_LEGACY;
            end
            OP_READ: begin
                resp_ok   = idle_ok && (byte_cnt >= CNT_W'(4));
                resp_byte = rd_data;
            end
            default: ;
        endcase
    end

    // Command capture, output shifting, deselect decisions and busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= 8'h00;
            addr_q     <= '0;
            wrsr_bp    <= 2'b00;
            wrsr_fz    <= 1'b0;
            pp_ptr     <= '0;
            pp_cnt     <= '0;
            wel_q      <= 1'b0;
            busy_q     <= 1'b0;
            srwd_q     <= 1'b0;
            dpd_q      <= 1'b0;
            bp_q       <= 2'b00;
            tx_sh      <= 8'h00;
            miso_q     <= 1'b0;
            tx_act     <= 1'b0;
            be_start_q <= 1'b0;
            be_op_q    <= BE_PROG;
            be_addr_q  <= '0;
            be_len_q   <= '0;
            be_stat_q  <= 8'h00;
        end else begin
            be_start_q <= 1'b0;

            // Byte capture: opcode, address, status data, program pointer.
            if (byte_done) begin
                if (byte_cnt == CNT_W'(0))
                    op_q <= rx_byte;
                else if (byte_cnt <= CNT_W'(3))
                    addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
                if (byte_cnt == CNT_W'(1)) begin
                    wrsr_bp <= rx_byte[3:2];
                    wrsr_fz <= rx_byte[7];
                end
                if (op_q == OP_PROG && byte_cnt == CNT_W'(3)) begin
                    pp_ptr <= rx_byte[PAGE_W-1:0];
                    pp_cnt <= '0;
                end
                if (buf_we) begin
                    pp_ptr <= pp_ptr + PAGE_W'(1);
                    if (pp_cnt != PAGE_BYTES)
                        pp_cnt <= pp_cnt + LEN_W'(1);
                end
            end

            // Data out: load a new byte at a byte boundary, else shift.
            if (!sel) begin
                tx_act <= 1'b0;
            end else if (fall) begin
                if (bit_cnt == 3'd0) begin
                    tx_act <= resp_ok;
                    if (resp_ok) begin
                        miso_q <= resp_byte[7];
                        tx_sh  <= {resp_byte[6:0], 1'b0};
                        if (op_q == OP_READ)
                            addr_q <= addr_q + ADDR_W'(1);
                    end
                end else begin
                    miso_q <= tx_sh[7];
                    tx_sh  <= {tx_sh[6:0], 1'b0};
                end
            end

            // Deselect: decide whether the finished command takes effect.
            if (desel && have1) begin
                case (op_q)
                    OP_WREN: if (idle_ok) wel_q <= 1'b1;
                    OP_WRDI: if (idle_ok) wel_q <= 1'b0;
                    OP_WRSR: if (mod_ok && byte_cnt >= CNT_W'(2) && !frozen) begin
                        bp_q       <= wrsr_bp;
                        srwd_q     <= wrsr_fz;
                        be_stat_q  <= {wrsr_fz, 3'b000, wrsr_bp, 2'b00};
                        be_op_q    <= BE_STAT;
                        be_start_q <= 1'b1;
                        busy_q     <= 1'b1;
                    end
                    OP_PROG: if (mod_ok && byte_cnt >= CNT_W'(5) && !sect_locked) begin
                        be_addr_q  <= addr_q;
                        be_len_q   <= pp_cnt;
                        be_op_q    <= BE_PROG;
                        be_start_q <= 1'b1;
                        busy_q     <= 1'b1;
                    end
                    OP_SERASE: if (mod_ok && byte_cnt >= CNT_W'(4) && !sect_locked) begin
                        be_addr_q  <= addr_q;
                        be_op_q    <= BE_SECT;
                        be_start_q <= 1'b1;
                        busy_q     <= 1'b1;
                    end
                    OP_BERASE: if (mod_ok && none_locked) begin
                        be_addr_q  <= '0;
                        be_op_q    <= BE_BULK;
                        be_start_q <= 1'b1;
                        busy_q     <= 1'b1;
                    end
                    OP_SLEEP: if (idle_ok && bit_cnt == 3'd0) dpd_q <= 1'b1;
                    OP_WAKE:  if (!busy_q) dpd_q <= 1'b0;
                    default: ;
                endcase
            end

            // Backend completion ends busy and drops the latch.
            if (be_done && busy_q) begin
                busy_q <= 1'b0;
                wel_q  <= 1'b0;
            end
        end
    end

    assign spi_miso    = miso_q;
    assign spi_miso_oe = sel && hold_ok && tx_act;
    assign rd_addr     = addr_q;
    assign be_start    = be_start_q;
    assign be_op       = be_op_q;
    assign be_addr     = be_addr_q;
    assign be_len      = be_len_q;
    assign be_stat     = be_stat_q;

    a_r4_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |-> wel_q);
    a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> be_start);
    a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (be_done && busy_q) |=> (!busy_q && !wel_q));
    a_r9_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |=> !be_start);
    a_r10_sleep_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_q |-> !be_start);
    a_r7_bulk_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (be_start && be_op == 2'd2) |-> (bp_q == 2'b00));
    a_r13_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        (be_start && be_op == 2'd0) |-> (be_len != '0 && be_len <= PAGE_BYTES));
endmodule

// File: tb/sfc_flash_ctrl_test.sv
module sfc_flash_ctrl_test;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
    logic miso, miso_oe, be_start, be_done = 1'b0;
    logic [17:0] rd_addr, be_addr;
    logic [7:0]  rd_data, be_stat, be_buf_data;
    logic [7:0]  be_buf_idx = 8'h00;
    logic [1:0]  be_op;
    logic [8:0]  be_len;

    int n_chk = 0, n_fail = 0, n_start = 0;
    logic [1:0]  c_op;
    logic [17:0] c_addr;
    logic [8:0]  c_len;
    logic [7:0]  c_stat;
    logic        oe_seen;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_val(input logic [17:0] a);
        return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]};
    endfunction
    assign rd_data = mem_val(rd_addr);

    sfc_flash_ctrl uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_wp_n(wp_n), .spi_hold_n(hold_n),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .rd_addr(rd_addr),
        .rd_data(rd_data), .be_start(be_start), .be_op(be_op),
        .be_addr(be_addr), .be_len(be_len), .be_stat(be_stat),
        .be_buf_idx(be_buf_idx), .be_buf_data(be_buf_data), .be_done(be_done)
    );

    always @(negedge clk) begin
        if (rst_n && be_start) begin
            n_start++;
            c_op = be_op; c_addr = be_addr; c_len = be_len; c_stat = be_stat;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk) mosi = tx[i];
            repeat (H) @(negedge clk);
            rx[i] = miso;
            if (miso_oe) oe_seen = 1'b1;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic sel_on();
        @(negedge clk) cs_n = 1'b0;
        oe_seen = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic sel_off();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel_on(); xfer(op, r); sel_off();
    endtask

    task automatic cmd_addr(input logic [7:0] op, input logic [17:0] a, input int extra_bits);
        logic [7:0] r;
        sel_on();
        xfer(op, r); xfer({6'b0, a[17:16]}, r); xfer(a[15:8], r); xfer(a[7:0], r);
        if (extra_bits > 0) xbits(8'hFF, extra_bits, r);
        sel_off();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        sel_on(); xfer(8'h01, r); xfer(v, r); sel_off();
    endtask

    task automatic read_status(output logic [7:0] s);
        logic [7:0] r;
        sel_on(); xfer(8'h05, r); xfer(8'h00, s); sel_off();
    endtask

    task automatic done_pulse();
        @(negedge clk) be_done = 1'b1;
        @(negedge clk) be_done = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1 oe", miso_oe, 0);
        chk("R1 start", n_start, 0);
        read_status(s);
        chk("R1 status", s, 8'h00);
    endtask

    task automatic t_latch_and_status();
        logic [7:0] s, r, s2;
        cmd1(8'h06);
        sel_on(); xfer(8'h05, r); xfer(8'h00, s); xfer(8'h00, s2); sel_off();
        chk("R3 wren", s, 8'h02);
        chk("R2 repeat", s2, 8'h02);
        cmd1(8'h04);
        read_status(s);
        chk("R3 wrdi", s, 8'h00);
    endtask

    task automatic t_ident();
        logic [7:0] r, a, b;
        sel_on(); xfer(8'h9F, r); xfer(8'h00, a); xfer(8'h00, b); sel_off();
        chk("R11 id hi", a, 8'h20);
        chk("R11 id lo", b, 8'h12);
    endtask

    task automatic t_read();
        logic [7:0] r, a, b;
        sel_on();
        xfer(8'h03, r); xfer(8'h01, r); xfer(8'h23, r); xfer(8'h45, r);
        xfer(8'h00, a); xfer(8'h00, b);
        sel_off();
        chk("R12 byte0", a, mem_val(18'h12345));
        chk("R12 byte1", b, mem_val(18'h12346));
    endtask

    task automatic t_no_latch_and_partial();
        logic [7:0] s;
        int n0 = n_start;
        cmd_addr(8'hD8, 18'h00000, 0);
        chk("R4 no latch", n_start, n0);
        cmd1(8'h06);
        cmd_addr(8'hD8, 18'h00000, 1);
        chk("R5 partial", n_start, n0);
        read_status(s);
        chk("R5 latch kept", s, 8'h02);
    endtask

    task automatic t_busy();
        logic [7:0] s, r;
        int n0 = n_start;
        cmd_addr(8'hD8, 18'h30000, 0);
        chk("R6 se start", n_start, n0 + 1);
        chk("R6 se op", c_op, 2'd1);
        chk("R6 se addr", c_addr, 18'h30000);
        read_status(s);
        chk("R9 busy", s, 8'h03);
        sel_on(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r);
        xfer(8'h55, r); sel_off();
        chk("R9 ignored busy", n_start, n0 + 1);
        done_pulse();
        read_status(s);
        chk("R9 done", s, 8'h00);
    endtask

    task automatic t_protect();
        logic [7:0] s, r;
        int n0;
        cmd1(8'h06);
        n0 = n_start;
        wrsr(8'h84);
        chk("R8 wrsr start", n_start, n0 + 1);
        chk("R8 wrsr op", c_op, 2'd3);
        chk("R8 wrsr stat", c_stat, 8'h84);
        done_pulse();
        read_status(s);
        chk("R8 status", s, 8'h84);
        cmd1(8'h06);
        n0 = n_start;
        sel_on(); xfer(8'h02, r); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h00, r);
        xfer(8'hAA, r); sel_off();
        chk("R6 locked", n_start, n0);
        cmd1(8'hC7);
        chk("R7 bulk locked", n_start, n0);
        sel_on(); xfer(8'h02, r); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h00, r);
        xfer(8'hAA, r); sel_off();
        chk("R6 open start", n_start, n0 + 1);
        chk("R6 open addr", c_addr, 18'h20000);
        chk("R6 open op", c_op, 2'd0);
        done_pulse();
        cmd1(8'h06);
        wp_n = 1'b0;
        n0 = n_start;
        wrsr(8'h00);
        chk("R8 frozen", n_start, n0);
        read_status(s);
        chk("R8 frozen stat", s, 8'h86);
        wp_n = 1'b1;
        wrsr(8'h00);
        chk("R8 unfrozen", n_start, n0 + 1);
        done_pulse();
        read_status(s);
        chk("R8 cleared", s, 8'h00);
        cmd1(8'h06);
        cmd1(8'hC7);
        chk("R7 bulk ok", n_start, n0 + 2);
        chk("R7 bulk op", c_op, 2'd2);
        done_pulse();
    endtask

    task automatic t_page();
        logic [7:0] r;
        cmd1(8'h06);
        sel_on(); xfer(8'h02, r); xfer(8'h01, r); xfer(8'h00, r); xfer(8'hFE, r);
        xfer(8'hA1, r); xfer(8'hB2, r); xfer(8'hC3, r); xfer(8'hD4, r); sel_off();
        chk("R13 addr", c_addr, 18'h100FE);
        chk("R13 len", c_len, 9'd4);
        @(negedge clk) be_buf_idx = 8'hFF;
        @(negedge clk) chk("R13 ff", be_buf_data, 8'hB2);
        be_buf_idx = 8'h01;
        @(negedge clk) chk("R13 wrap", be_buf_data, 8'hD4);
        done_pulse();
        cmd1(8'h06);
        sel_on(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h10, r);
        for (int i = 0; i < 257; i++) xfer((i == 256) ? 8'hEE : 8'(i), r);
        sel_off();
        chk("R13 len sat", c_len, 9'd256);
        @(negedge clk) be_buf_idx = 8'h10;
        @(negedge clk) chk("R13 overwrite", be_buf_data, 8'hEE);
        be_buf_idx = 8'h0F;
        @(negedge clk) chk("R13 last", be_buf_data, 8'hFF);
        done_pulse();
    endtask

    task automatic t_sleep();
        logic [7:0] s, r;
        int n0;
        cmd1(8'h06);
        cmd1(8'hB9);
        n0 = n_start;
        cmd_addr(8'hD8, 18'h00000, 0);
        chk("R10 erase ignored", n_start, n0);
        sel_on(); xfer(8'h05, r); xfer(8'h00, r); sel_off();
        chk("R10 no status out", oe_seen, 0);
        sel_on(); xfer(8'hAB, r); xfer(8'h00, s); xfer(8'h00, r); sel_off();
        chk("R10 sig", s, 8'h11);
        chk("R10 sig again", r, 8'h11);
        read_status(s);
        chk("R10 awake", s, 8'h02);
        cmd1(8'h04);
    endtask

    task automatic t_hold();
        logic [7:0] s, r;
        sel_on();
        xbits(8'h06, 4, r);
        @(negedge clk) hold_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            mosi = 1'b1;
            repeat (H) @(negedge clk) sck = 1'b1;
            repeat (H) @(negedge clk) sck = 1'b0;
        end
        hold_n = 1'b1;
        repeat (4) @(negedge clk);
        xbits(8'h60, 4, r);
        sel_off();
        read_status(s);
        chk("R14 split byte", s, 8'h02);
        sel_on(); xfer(8'h05, r);
        @(negedge clk) hold_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R14 oe off", miso_oe, 0);
        hold_n = 1'b1;
        repeat (6) @(negedge clk);
        xfer(8'h00, s); sel_off();
        chk("R14 resume", s, 8'h02);
        cmd1(8'h04);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_latch_and_status();
        t_ident();
        t_read();
        t_no_latch_and_partial();
        t_busy();
        t_protect();
        t_page();
        t_sleep();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule